// File: doc/BRIEF.md
# Dual Mode-Configurable Timer/Counter

This block holds two 16-bit counting channels, each made of a low byte and a high byte. It runs on the oscillator clock. An internal phase generator splits that clock into machine cycles of twelve oscillator periods. A channel counts in one of two ways. As a timer, it advances once per machine cycle. As an event counter, it counts falling edges on its external count pin, sampled once per machine cycle. A per-channel gate option makes counting also depend on a gate pin, which allows pulse-width measurement.

Software reaches the block through a small register port. The write side is a plain strobe with address and data. The read side is a combinational read of the addressed register; there is no handshake or back-pressure. A mode register selects, per channel, the gate option, the count source and one of four widths:
- a 13-bit count with a 5-bit prescaler;
- a 16-bit count;
- an 8-bit count with reload;
- a split mode in which channel 0 becomes two independent 8-bit counters and channel 1 stops.

A control register holds the two run bits and the two overflow flags. The flags also drive output pins.

Top module: `dual_tmr_ctr`

## Requirements
- R1: In timer function, an enabled channel advances by exactly one per twelve clock cycles. Any window of 12·k consecutive clock edges with the channel enabled adds exactly k.
- R2: In counter function (source bit = 1), the count pin is sampled once per machine cycle. The count advances once for each high sample followed by a low sample. The new value appears between 13 and 24 clock edges after the pin falls. A pin held at a steady level adds nothing.
- R3: In mode 0 (mode code 00), bits 4:0 of the low byte act as a prescaler into the high byte, forming a 13-bit count. Bits 7:5 of the low byte are left untouched. A wrap from all ones to zero sets the channel's overflow flag.
- R4: In mode 1 (code 01), the high byte and the low byte form one 16-bit count. A wrap from 0xFFFF to 0x0000 sets the channel's overflow flag.
- R5: In mode 2 (code 10), only the low byte counts. When the low byte wraps from 0xFF, it is loaded from the high byte and the overflow flag is set. The high byte is unchanged.
- R6: In mode 3 (code 11) on channel 0, the low byte counts under run bit 0, gate and source of channel 0, and sets flag 0. The high byte counts machine cycles under run bit 1 and sets flag 1.
- R7: Channel 1 holds its count whenever either channel's mode field is 3, even with run bit 1 set.
- R8: A channel counts only when its run bit is 1 and either its gate bit is 0 or its gate pin is high.
- R9: With its run bit clear, a channel's count bytes do not change.
- R10: A register write to a count byte takes priority over an increment in the same cycle.
- R11: Register map, by address:

  | Address | Register |
  |---|---|
  | 0 | mode |
  | 1 | control |
  | 2 | channel 0 low byte |
  | 3 | channel 0 high byte |
  | 4 | channel 1 low byte |
  | 5 | channel 1 high byte |

  Mode register fields:
  - Each channel has a nibble laid out as gate (bit 3), source (bit 2, 1 = external pin) and mode (bits 1:0).
  - Channel 0 uses bits 3:0 and channel 1 uses bits 7:4.

  Control register fields:
  - Bit 0 is run 0 and bit 1 is run 1.
  - Bit 2 is flag 0 and bit 3 is flag 1.
  - A write of 0 to a flag bit clears it.

  After reset, all registers read 0 and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| cnt_pin | input | 2 | External count inputs, one per channel |
| gate_pin | input | 2 | Gate inputs, one per channel |
| ovf_flag | output | 2 | Overflow flags, one per channel |

## Verification
The assertions check four things on every cycle:
- the machine-cycle phase stays in range;
- an edge detection follows a low pin sample;
- a stopped or frozen channel keeps its bytes, and a written byte takes the written value;
- a mode-2 wrap loads the high byte, and a reported wrap raises its flag.

Only the bench scenarios can show the count rates over whole windows, the 13-bit and split-mode wrap points, gate qualification, the timing of event counting and the register layout.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 8;
  localparam int NCH    = 2;
  localparam logic [2:0] ADR_MODE = 3'd0;
  localparam logic [2:0] ADR_CTRL = 3'd1;
  localparam int         ADR_CNT_BASE = 2;

  typedef enum logic [1:0] {
    MD_PRE13   = 2'd0,
    MD_FULL16  = 2'd1,
    MD_RELOAD8 = 2'd2,
    MD_SPLIT   = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_sel;
    tmr_mode_e mode;
  } chan_cfg_t;
endpackage

// File: rtl/mc_phase.sv
module mc_phase #(
  parameter int CYCLE_LEN = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(CYCLE_LEN);
  localparam logic [CW-1:0] LAST = CW'(CYCLE_LEN - 1);
  logic [CW-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                ph_q <= ph_q + CW'(1);
  end

  assign tick = (ph_q == LAST);

  assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= LAST);
  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/fall_sampler.sv
module fall_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall_pend
);
  logic smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q     <= 1'b0;
      fall_pend <= 1'b0;
    end else if (tick) begin
      smp_q     <= pin;
      fall_pend <= smp_q & ~pin;
    end
  end

  assert_fall_from_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_pend && !$past(fall_pend)) |-> ($past(tick) && !$past(pin)));
  assert_fall_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(fall_pend));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  chan_cfg_t         cfg,
  input  logic              run,
  input  logic              gate_in,
  input  logic              fall_pend,
  input  logic              alt_run,
  input  logic              freeze,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf_main,
  output logic              ovf_alt
);
  localparam logic [BYTE_W-1:0]   ONE_B = BYTE_W'(1);
  localparam logic [PRE_W-1:0]    ONE_P = PRE_W'(1);
  localparam logic [2*BYTE_W-1:0] ONE_W = (2*BYTE_W)'(1);

  logic step, en, inc, alt_inc;
  logic [BYTE_W-1:0] lo_nx, hi_nx;

  assign step    = tick & (cfg.ext_sel ? fall_pend : 1'b1);
  assign en      = run & (~cfg.gate | gate_in) & ~freeze;
  assign inc     = en & step;
  assign alt_inc = tick & alt_run & (cfg.mode == MD_SPLIT);

  always_comb begin
    lo_nx    = lo_q;
    hi_nx    = hi_q;
    ovf_main = 1'b0;
    ovf_alt  = 1'b0;
    case (cfg.mode)
      MD_PRE13: if (inc) begin
        if (&lo_q[PRE_W-1:0]) begin
          lo_nx[PRE_W-1:0] = '0;
          hi_nx            = hi_q + ONE_B;
          ovf_main         = &hi_q;
        end else begin
          lo_nx[PRE_W-1:0] = lo_q[PRE_W-1:0] + ONE_P;
        end
      end
      MD_FULL16: if (inc) begin
        {hi_nx, lo_nx} = {hi_q, lo_q} + ONE_W;
        ovf_main       = &{hi_q, lo_q};
      end
      MD_RELOAD8: if (inc) begin
        if (&lo_q) begin
          lo_nx    = hi_q;
          ovf_main = 1'b1;
        end else begin
          lo_nx = lo_q + ONE_B;
        end
      end
      default: begin
        if (inc) begin
          lo_nx    = lo_q + ONE_B;
          ovf_main = &lo_q;
        end
        if (alt_inc) begin
          hi_nx   = hi_q + ONE_B;
          ovf_alt = &hi_q;
        end
      end
    endcase
    if (wr_lo) lo_nx = wdata;
    if (wr_hi) hi_nx = wdata;
    if (wr_lo | wr_hi) ovf_main = 1'b0;
    if (wr_hi) ovf_alt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_nx;
      hi_q <= hi_nx;
    end
  end

  assert_stopped_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi && cfg.mode != MD_SPLIT) |=> ($stable(lo_q) && $stable(hi_q)));
  assert_frozen_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !alt_run && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wdata)));
  assert_reload_from_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MD_RELOAD8 && inc && (&lo_q) && !wr_lo && !wr_hi) |=> (lo_q == $past(hi_q)));
endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
  import tmr_pkg::*;
#(
  parameter int CYCLE_LEN = 12,
  parameter int PRE_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    cnt_pin,
  input  logic [NCH-1:0]    gate_pin,
  output logic [NCH-1:0]    ovf_flag
);
  localparam int NIB = DATA_W / NCH;

  logic                 tick;
  logic [DATA_W-1:0]    mode_q;
  logic [NCH-1:0]       run_q, flag_q;
  logic [NCH-1:0]       fall_pend, ovf_main, ovf_alt;
  logic [DATA_W-1:0]    lo_q [NCH];
  logic [DATA_W-1:0]    hi_q [NCH];
  logic                 ctrl_wr, split_any;
  chan_cfg_t            cfg  [NCH];

  mc_phase #(.CYCLE_LEN(CYCLE_LEN)) u_phase (.clk(clk), .rst_n(rst_n), .tick(tick));

  assign ctrl_wr   = bus_wr && (bus_addr == ADR_CTRL);
  assign split_any = (cfg[0].mode == MD_SPLIT) || (cfg[1].mode == MD_SPLIT);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr_lo, wr_hi;
    assign cfg[g] = chan_cfg_t'(mode_q[g*NIB +: NIB]);
    assign wr_lo  = bus_wr && (bus_addr == 3'(ADR_CNT_BASE + 2*g));
    assign wr_hi  = bus_wr && (bus_addr == 3'(ADR_CNT_BASE + 2*g + 1));

    fall_sampler u_smp (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pin(cnt_pin[g]), .fall_pend(fall_pend[g])
    );

    tmr_channel #(.BYTE_W(DATA_W), .PRE_W(PRE_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg[g]),
      .run(run_q[g]), .gate_in(gate_pin[g]), .fall_pend(fall_pend[g]),
      .alt_run((g == 0) ? run_q[1] : 1'b0),
      .freeze((g == 0) ? 1'b0 : split_any),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
      .lo_q(lo_q[g]), .hi_q(hi_q[g]),
      .ovf_main(ovf_main[g]), .ovf_alt(ovf_alt[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         flag_q[g] <= 1'b0;
      else if (ctrl_wr)                   flag_q[g] <= bus_wdata[NCH + g];
      else if (ovf_main[g] | ovf_alt[NCH-1-g]) flag_q[g] <= 1'b1;
    end

    assert_flag_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_main[g] && !ctrl_wr) |=> flag_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADR_MODE) mode_q <= bus_wdata;
      if (ctrl_wr)              run_q  <= bus_wdata[NCH-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADR_MODE) bus_rdata = mode_q;
    if (ctrl_wr || bus_addr == ADR_CTRL)
      bus_rdata = {{(DATA_W-2*NCH){1'b0}}, flag_q, run_q};
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == 3'(ADR_CNT_BASE + 2*c))     bus_rdata = lo_q[c];
      if (bus_addr == 3'(ADR_CNT_BASE + 2*c + 1)) bus_rdata = hi_q[c];
    end
  end

  assign ovf_flag = flag_q;

  assert_split_flag1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_alt[0] && !ctrl_wr) |=> flag_q[1]);
endmodule

// File: tb/dual_tmr_ctr_test.sv
module dual_tmr_ctr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] ovf_flag;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_MODE = 3'd0, A_CTRL = 3'd1, A_LO0 = 3'd2, A_HI0 = 3'd3,
                         A_LO1 = 3'd4, A_HI1 = 3'd5;

  dual_tmr_ctr uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .ovf_flag(ovf_flag)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic load(input logic [2:0] a_lo, input logic [7:0] lo, input logic [7:0] hi);
    wr(a_lo, lo);
    wr(a_lo + 3'd1, hi);
  endtask

  // run for exactly k machine cycles, then stop while keeping the flags
  task automatic run_window(input logic [7:0] on_val, input int k);
    wr(A_CTRL, on_val);
    repeat (12*k - 1) @(negedge clk);
    wr(A_CTRL, {4'b0, ovf_flag, 2'b00});
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R11 reset register", v, 0);
    end
    chk("R11 reset flags", ovf_flag, 0);
  endtask

  task automatic t_timer;
    logic [7:0] a, b;
    wr(A_MODE, 8'h01);
    load(A_LO0, 8'h00, 8'h00);
    run_window(8'h01, 7);
    rd(A_LO0, a);
    chk("R1 timer window count", a, 7);
    wr(A_CTRL, 8'h01);
    rd(A_LO0, a);
    repeat (120) @(negedge clk);
    rd(A_LO0, b);
    chk("R1 timer rate 1/12", 8'(b - a), 10);
    wr(A_CTRL, 8'h00);
    rd(A_LO0, a);
    repeat (60) @(negedge clk);
    rd(A_LO0, b);
    chk("R9 run clear holds", b, a);
  endtask

  task automatic t_counter;
    logic [7:0] v;
    wr(A_MODE, 8'h05);
    load(A_LO0, 8'h00, 8'h00);
    cnt_pin[0] = 1'b1;
    wr(A_CTRL, 8'h01);
    repeat (24) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      cnt_pin[0] = 1'b0; repeat (24) @(negedge clk);
      cnt_pin[0] = 1'b1; repeat (24) @(negedge clk);
    end
    rd(A_LO0, v);
    chk("R2 five falling edges", v, 5);
    cnt_pin[0] = 1'b0;
    repeat (12) @(negedge clk);
    rd(A_LO0, v);
    chk("R2 not yet visible at 12 clocks", v, 5);
    repeat (12) @(negedge clk);
    rd(A_LO0, v);
    chk("R2 visible by 24 clocks", v, 6);
    repeat (120) @(negedge clk);
    rd(A_LO0, v);
    chk("R2 steady low adds nothing", v, 6);
    cnt_pin[0] = 1'b1;
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_mode0;
    logic [7:0] l, h;
    wr(A_MODE, 8'h00);
    load(A_LO0, 8'h1D, 8'hFF);
    run_window(8'h01, 5);
    rd(A_LO0, l); rd(A_HI0, h);
    chk("R3 13-bit wrap low", l, 8'h02);
    chk("R3 13-bit wrap high", h, 8'h00);
    chk("R3 flag 0 set", ovf_flag, 2'b01);
    load(A_LO0, 8'hFE, 8'h10);
    run_window(8'h01, 3);
    rd(A_LO0, l); rd(A_HI0, h);
    chk("R3 prescaler carry keeps bits 7:5", l, 8'hE1);
    chk("R3 prescaler carry into high", h, 8'h11);
    wr(A_CTRL, 8'h00);
    chk("R11 flag cleared by write", ovf_flag, 2'b00);
  endtask

  task automatic t_mode1;
    logic [7:0] l, h;
    wr(A_MODE, 8'h01);
    load(A_LO0, 8'hFE, 8'hFF);
    run_window(8'h01, 3);
    rd(A_LO0, l); rd(A_HI0, h);
    chk("R4 16-bit wrap", {h, l}, 16'h0001);
    chk("R4 flag 0 set", ovf_flag, 2'b01);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_mode2;
    logic [7:0] l, h;
    wr(A_MODE, 8'h02);
    load(A_LO0, 8'hFE, 8'h80);
    run_window(8'h01, 4);
    rd(A_LO0, l); rd(A_HI0, h);
    chk("R5 reload from high", l, 8'h82);
    chk("R5 high unchanged", h, 8'h80);
    chk("R5 flag 0 set", ovf_flag, 2'b01);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_split;
    logic [7:0] l, h;
    wr(A_MODE, 8'h03);
    load(A_LO0, 8'hFE, 8'hFD);
    run_window(8'h01, 3);
    rd(A_LO0, l); rd(A_HI0, h);
    chk("R6 split low wraps", l, 8'h01);
    chk("R6 split high idle under run0", h, 8'hFD);
    chk("R6 flag 0 only", ovf_flag, 2'b01);
    wr(A_CTRL, 8'h00);
    run_window(8'h02, 4);
    rd(A_LO0, l); rd(A_HI0, h);
    chk("R6 split high under run1", h, 8'h01);
    chk("R6 split low idle under run1", l, 8'h01);
    chk("R6 flag 1 from high byte", ovf_flag, 2'b10);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_freeze;
    logic [7:0] l, h;
    wr(A_MODE, 8'h13);
    load(A_LO0, 8'h00, 8'h00);
    load(A_LO1, 8'h10, 8'h20);
    run_window(8'h03, 4);
    rd(A_LO1, l); rd(A_HI1, h);
    chk("R7 ch1 frozen by ch0 split low", l, 8'h10);
    chk("R7 ch1 frozen by ch0 split high", h, 8'h20);
    wr(A_MODE, 8'h31);
    run_window(8'h02, 4);
    rd(A_LO1, l);
    chk("R7 ch1 own mode 3 holds", l, 8'h10);
    wr(A_MODE, 8'h11);
    run_window(8'h02, 4);
    rd(A_LO1, l);
    chk("R1 ch1 counts in mode 1", l, 8'h14);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_gate;
    logic [7:0] l;
    wr(A_MODE, 8'h09);
    load(A_LO0, 8'h00, 8'h00);
    gate_pin[0] = 1'b0;
    run_window(8'h01, 5);
    rd(A_LO0, l);
    chk("R8 gate low blocks", l, 0);
    gate_pin[0] = 1'b1;
    run_window(8'h01, 5);
    rd(A_LO0, l);
    chk("R8 gate high counts", l, 5);
    gate_pin[0] = 1'b0;
    wr(A_MODE, 8'h01);
    run_window(8'h01, 3);
    rd(A_LO0, l);
    chk("R8 gate bit clear ignores pin", l, 8);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_write_prio;
    logic [7:0] a, b, h;
    int n = 0;
    wr(A_MODE, 8'h01);
    load(A_LO0, 8'h00, 8'h00);
    wr(A_CTRL, 8'h01);
    rd(A_LO0, a);
    b = a;
    while (b == a && n < 40) begin
      @(negedge clk);
      rd(A_LO0, b);
      n++;
    end
    repeat (11) @(negedge clk);
    wr(A_LO0, 8'h40);
    rd(A_LO0, b);
    chk("R10 write beats increment", b, 8'h40);
    rd(A_HI0, h);
    chk("R10 high untouched", h, 8'h00);
    wr(A_CTRL, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_counter();
    t_mode0();
    t_mode1();
    t_mode2();
    t_split();
    t_freeze();
    t_gate();
    t_write_prio();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule